// File: doc/BRIEF.md
# Minimum-Mode Bus Strobe Sequencer

This block steps a processor bus through its T-states (T1, T2, T3, any number of wait states, T4) and decodes the control strobes of a minimum-mode bus from the current state. A bus cycle is requested with `req_i` and a 3-bit cycle type. The sequencer produces an address latch pulse in T1. In T2, T3 and every wait state it drives a write strobe or an interrupt acknowledge strobe, as the cycle type calls for. It also drives the memory/IO select and the transceiver direction.

A hold request lets another bus master take the bus. The request is granted from idle on the next clock, or after the T4 of a cycle that is already running. While hold is granted, the floatable outputs have their output enables removed. The address latch enable stays driven.

Top module: `bus_strobe_seq`

## Requirements
- R1: While reset is asserted, `ale_o`=0, `wr_n_o`=1, `inta_n_o`=1, `mio_o`=0, `dtr_o`=0, `hlda_o`=0, and all three output enables are 1.
- R2: `ale_o` is high for exactly the one T1 clock of each bus cycle and is low in every other state.
- R3: The cycle type is encoded as follows: bit 2 set means interrupt acknowledge, bit 1 set means I/O, and bit 0 set means write. So 000 is memory read, 001 is memory write, 010 is I/O read, 011 is I/O write and 100 is interrupt acknowledge. For a write cycle, `wr_n_o` is low in T2, T3 and every wait state, and high otherwise.
- R4: For an interrupt acknowledge cycle, `inta_n_o` is low in T2, T3 and every wait state, and high otherwise. `wr_n_o` stays high during such a cycle.
- R5: `ready_i` is sampled on the clock that leaves T3 and on the clock that leaves each wait state. If it is low, one more wait state follows. If it is high, T4 follows.
- R6: `mio_o` is 1 for memory cycles and 0 for I/O and interrupt acknowledge cycles. `dtr_o` is 1 for writes and 0 otherwise. Both take the new cycle's value from its T1 when the cycle starts from idle or from an unchained T4. They then hold that value through the cycle's T4, and also while the bus is idle.
- R7: If a request is present on the clock that enters T4 and hold is not requested, that request is chained. Its `mio_o` and `dtr_o` values appear during the T4, and its T1 follows the T4 directly.
- R8: A hold request seen on a clock while the bus is idle raises `hlda_o` from the next cycle.
- R9: A hold request that arrives during T2, T3 or a wait state is granted only after the T4. A hold request present on the clock that enters T4 prevents a pending request from being chained.
- R10: While `hlda_o` is high, `wr_oe_o`, `mio_oe_o` and `dtr_oe_o` are 0 and `ale_o` is driven 0. One clock after the hold request drops, the bus is idle and the output enables return to 1.
- R11: When a hold request and a cycle request are both present on a clock while the bus is idle, hold wins. The request starts its T1 only after hold has been released.
- R12: With no request and no hold, the sequencer stays idle and all strobes stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus cycle request, held until T1 is seen |
| req_type_i | input | 3 | Cycle type: bit 2 interrupt acknowledge, bit 1 I/O, bit 0 write |
| ready_i | input | 1 | Low inserts wait states after T3 |
| hold_req_i | input | 1 | Request from another bus master for the bus |
| ale_o | output | 1 | Address latch enable, high in T1 |
| wr_n_o | output | 1 | Write strobe, active low |
| inta_n_o | output | 1 | Interrupt acknowledge strobe, active low |
| mio_o | output | 1 | Memory (1) or I/O (0) select |
| dtr_o | output | 1 | Transceiver direction, transmit (1) or receive (0) |
| wr_oe_o | output | 1 | Output enable for the write strobe |
| mio_oe_o | output | 1 | Output enable for the memory/IO select |
| dtr_oe_o | output | 1 | Output enable for the transceiver direction |
| hlda_o | output | 1 | Hold acknowledge |

## Verification
Every cycle type is run once, each with zero, one or two wait states. These runs tell the two strobes apart from each other and from reads, and they show that wait states stretch only the strobe window. Back-to-back cycles are run two ways: chained, with the request present as T4 is entered, and unchained, with the request present only as T4 is left. The two cases differ only in whether the status lines change during T4 or in T1. Hold is tried from idle, together with a simultaneous request, and during a running cycle that also has a pending request. These runs show the grant latency, the priority over a request, the deferral to after T4 and the suppression of chaining.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int unsigned CYC_W = 3;
  localparam int unsigned BIT_WR = 0;
  localparam int unsigned BIT_IO = 1;
  localparam int unsigned BIT_INTA = 2;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5,
    TS_HOLD = 3'd6
  } tstate_e;
endpackage

// File: rtl/bss_tstate_fsm.sv
module bss_tstate_fsm
  import bss_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    ready_i,
  input  logic    hold_req_i,
  output tstate_e state_o,
  output logic    load_o
);
  tstate_e state_q, state_d;
  logic    chain_q, chain_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE: begin
        if (hold_req_i)  state_d = TS_HOLD;
        else if (req_i)  state_d = TS_T1;
      end
      TS_T1:   state_d = TS_T2;
      TS_T2:   state_d = TS_T3;
      TS_T3, TS_TW: state_d = ready_i ? TS_T4 : TS_TW;
      TS_T4: begin
        if (chain_q)         state_d = TS_T1;
        else if (hold_req_i) state_d = TS_HOLD;
        else if (req_i)      state_d = TS_T1;
        else                 state_d = TS_IDLE;
      end
      TS_HOLD: if (!hold_req_i) state_d = TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  // next cycle is chained when its request is seen entering T4
  assign chain_d = (state_d == TS_T4) && req_i && !hold_req_i;

  always_comb begin
    load_o = chain_d;
    if (state_q == TS_IDLE && !hold_req_i && req_i) load_o = 1'b1;
    if (state_q == TS_T4 && !chain_q && !hold_req_i && req_i) load_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      chain_q <= 1'b0;
    end else begin
      state_q <= state_d;
      chain_q <= chain_d;
    end
  end

  assign state_o = state_q;

  p_wait_on_not_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_TW) |-> $past(!ready_i));

  p_t4_after_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == TS_T3 || state_q == TS_TW) && ready_i) |=> (state_q == TS_T4));

  p_no_hold_mid_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_HOLD && $past(state_q) != TS_HOLD)
      |-> ($past(state_q) == TS_IDLE || $past(state_q) == TS_T4));
endmodule

// File: rtl/bss_cyc_reg.sv
module bss_cyc_reg
  import bss_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CYC_W-1:0] type_i,
  input  tstate_e          state_i,
  output logic             mio_o,
  output logic             dtr_o,
  output logic             is_wr_o,
  output logic             is_inta_o
);
  logic mio_q, dtr_q, wr_q, inta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mio_q  <= 1'b0;
      dtr_q  <= 1'b0;
      wr_q   <= 1'b0;
      inta_q <= 1'b0;
    end else if (load_i) begin
      mio_q  <= !type_i[BIT_IO] && !type_i[BIT_INTA];
      dtr_q  <= type_i[BIT_WR] && !type_i[BIT_INTA];
      wr_q   <= type_i[BIT_WR] && !type_i[BIT_INTA];
      inta_q <= type_i[BIT_INTA];
    end
  end

  assign mio_o     = mio_q;
  assign dtr_o     = dtr_q;
  assign is_wr_o   = wr_q;
  assign is_inta_o = inta_q;

  p_status_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == TS_T2 || state_i == TS_T3 || state_i == TS_TW)
      |-> ($stable(mio_o) && $stable(dtr_o)));
endmodule

// File: rtl/bss_strobe_dec.sv
module bss_strobe_dec
  import bss_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  tstate_e state_i,
  input  logic    is_wr_i,
  input  logic    is_inta_i,
  output logic    ale_o,
  output logic    wr_n_o,
  output logic    inta_n_o,
  output logic    oe_o,
  output logic    hlda_o
);
  logic data_phase;

  assign data_phase = (state_i == TS_T2) || (state_i == TS_T3) || (state_i == TS_TW);
  assign ale_o      = (state_i == TS_T1);
  assign wr_n_o     = !(data_phase && is_wr_i);
  assign inta_n_o   = !(data_phase && is_inta_i);
  assign hlda_o     = (state_i == TS_HOLD);
  assign oe_o       = !hlda_o;

  p_ale_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  p_wr_follows_ale_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_n_o) |-> $past(ale_o));

  p_inta_follows_ale_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(inta_n_o) |-> $past(ale_o));

  p_float_in_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!oe_o && !ale_o && wr_n_o && inta_n_o));
endmodule

// File: rtl/bus_strobe_seq.sv
module bus_strobe_seq
  import bss_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CYC_W-1:0] req_type_i,
  input  logic             ready_i,
  input  logic             hold_req_i,
  output logic             ale_o,
  output logic             wr_n_o,
  output logic             inta_n_o,
  output logic             mio_o,
  output logic             dtr_o,
  output logic             wr_oe_o,
  output logic             mio_oe_o,
  output logic             dtr_oe_o,
  output logic             hlda_o
);
  tstate_e state;
  logic    load, is_wr, is_inta, oe;

  bss_tstate_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .ready_i    (ready_i),
    .hold_req_i (hold_req_i),
    .state_o    (state),
    .load_o     (load)
  );

  bss_cyc_reg u_cyc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .type_i    (req_type_i),
    .state_i   (state),
    .mio_o     (mio_o),
    .dtr_o     (dtr_o),
    .is_wr_o   (is_wr),
    .is_inta_o (is_inta)
  );

  bss_strobe_dec u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .is_wr_i   (is_wr),
    .is_inta_i (is_inta),
    .ale_o     (ale_o),
    .wr_n_o    (wr_n_o),
    .inta_n_o  (inta_n_o),
    .oe_o      (oe),
    .hlda_o    (hlda_o)
  );

  assign wr_oe_o  = oe;
  assign mio_oe_o = oe;
  assign dtr_oe_o = oe;

  p_idle_grant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_o && wr_n_o && inta_n_o && !hlda_o && hold_req_i && $past(hlda_o))
      |=> hlda_o);
endmodule

// File: tb/bus_strobe_seq_tb.sv
module bus_strobe_seq_tb;
  typedef struct packed {
    logic ale, wr_n, inta_n, mio, dtr, wr_oe, mio_oe, dtr_oe, hlda;
  } obs_t;

  typedef struct {
    obs_t  v;
    string tag;
  } exp_t;

  localparam logic [2:0] MEMRD = 3'b000, MEMWR = 3'b001, IORD = 3'b010,
                         IOWR = 3'b011, INTA = 3'b100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, ready = 1'b1, hold = 1'b0;
  logic [2:0] rtype = 3'b000;
  obs_t act;

  int checks = 0, fails = 0;
  bit done = 1'b0, drv_done = 1'b0;
  exp_t q[$];
  logic cur_mio = 1'b0, cur_dtr = 1'b0;

  always #4 clk = ~clk;

  bus_strobe_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_type_i(rtype),
    .ready_i(ready), .hold_req_i(hold),
    .ale_o(act.ale), .wr_n_o(act.wr_n), .inta_n_o(act.inta_n),
    .mio_o(act.mio), .dtr_o(act.dtr), .wr_oe_o(act.wr_oe),
    .mio_oe_o(act.mio_oe), .dtr_oe_o(act.dtr_oe), .hlda_o(act.hlda)
  );

  function automatic obs_t mk(logic ale, logic wrn, logic intan, logic hl);
    obs_t o;
    o.ale = ale; o.wr_n = wrn; o.inta_n = intan;
    o.mio = cur_mio; o.dtr = cur_dtr;
    o.wr_oe = !hl; o.mio_oe = !hl; o.dtr_oe = !hl; o.hlda = hl;
    return o;
  endfunction

  function automatic void set_status(logic [2:0] t);
    cur_mio = !t[1] && !t[2];
    cur_dtr = t[0] && !t[2];
  endfunction

  // one clock: inputs applied now act at the next edge, expectation queued after it
  task automatic step(logic r, logic [2:0] t, logic rd, logic h, obs_t e, string tag);
    exp_t x;
    @(negedge clk);
    req = r; rtype = t; ready = rd; hold = h;
    @(posedge clk);
    #1;
    x.v = e; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic idle_step();
    step(1'b0, 3'b000, 1'b1, 1'b0, mk(1'b0, 1'b1, 1'b1, 1'b0), "R12");
  endtask

  task automatic do_cycle(logic [2:0] t, int nwait, bit chained,
                          bit nreq, logic [2:0] nt, bit h);
    logic wr_act, ia_act;
    string stag;
    wr_act = t[0] && !t[2];
    ia_act = t[2];
    stag = ia_act ? "R4" : "R3";
    if (!chained) set_status(t);
    step(1'b1, t, 1'b1, 1'b0, mk(1'b1, 1'b1, 1'b1, 1'b0), "R2");
    step(1'b0, t, 1'b1, h, mk(1'b0, !wr_act, !ia_act, 1'b0), stag);
    step(1'b0, t, 1'b1, h, mk(1'b0, !wr_act, !ia_act, 1'b0), stag);
    for (int w = 0; w < nwait; w++)
      step(1'b0, t, 1'b0, h, mk(1'b0, !wr_act, !ia_act, 1'b0), "R5");
    if (nreq && !h) set_status(nt);
    step(nreq, nt, 1'b1, h, mk(1'b0, 1'b1, 1'b1, 1'b0), nreq ? (h ? "R9" : "R7") : "R6");
  endtask

  task automatic hold_step(logic r, string tag);
    step(r, MEMRD, 1'b1, 1'b1, mk(1'b0, 1'b1, 1'b1, 1'b1), tag);
  endtask

  task automatic release_step(logic r);
    step(r, MEMRD, 1'b1, 1'b0, mk(1'b0, 1'b1, 1'b1, 1'b0), "R10");
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        checks++;
        if (act !== x.v) begin
          fails++;
          $display("FAIL %s t=%0t actual=%b expected=%b", x.tag, $time, act, x.v);
        end
      end else if (drv_done) begin
        summary();
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog t=%0t actual=running expected=finished", $time);
    summary();
  end

  // driver
  initial begin
    #10;
    checks++;
    if (act !== obs_t'(9'b0_1_1_0_0_1_1_1_0)) begin
      fails++;
      $display("FAIL R1 actual=%b expected=%b", act, 9'b011001110);
    end
    @(negedge clk);
    rst_n = 1'b1;

    idle_step(); idle_step();
    do_cycle(MEMRD, 0, 1'b0, 1'b0, MEMRD, 1'b0);
    idle_step();
    do_cycle(MEMWR, 2, 1'b0, 1'b0, MEMRD, 1'b0);
    idle_step();
    do_cycle(IORD, 1, 1'b0, 1'b0, MEMRD, 1'b0);
    do_cycle(IOWR, 0, 1'b0, 1'b0, MEMRD, 1'b0);    // unchained back-to-back (R6)
    idle_step();
    do_cycle(INTA, 1, 1'b0, 1'b0, MEMRD, 1'b0);
    idle_step(); idle_step();
    // chained: memwr -> iord -> inta
    do_cycle(MEMWR, 0, 1'b0, 1'b1, IORD, 1'b0);
    do_cycle(IORD, 1, 1'b1, 1'b1, INTA, 1'b0);
    do_cycle(INTA, 0, 1'b1, 1'b0, MEMRD, 1'b0);
    idle_step();
    // hold from idle (R8, R10)
    hold_step(1'b0, "R8"); hold_step(1'b0, "R10"); hold_step(1'b0, "R10");
    release_step(1'b0);
    idle_step();
    // hold beats request (R11)
    hold_step(1'b1, "R11"); hold_step(1'b1, "R11");
    release_step(1'b1);
    do_cycle(MEMWR, 0, 1'b0, 1'b0, MEMRD, 1'b0);
    idle_step();
    // hold during cycle with pending request: deferred, no chaining (R9)
    do_cycle(IOWR, 1, 1'b0, 1'b1, MEMRD, 1'b1);
    hold_step(1'b0, "R9"); hold_step(1'b0, "R10");
    release_step(1'b0);
    idle_step();
    do_cycle(MEMRD, 0, 1'b0, 1'b0, MEMRD, 1'b0);
    idle_step();
    drv_done = 1'b1;
  end
endmodule